// File: doc/BRIEF.md
# Trigger Window Event Allocator

This block serves one synchronized input channel of a readout board. Each clock cycle stands for one bunch crossing. A word arriving on the channel carries a payload and a 3-bit lag that tells how many crossings late it arrives relative to the crossing that produced it. A trigger-accept pulse can arrive in any crossing. The block keeps only words whose crossing of origin falls inside a configurable window around an accept. The window runs from up to 3 crossings before the accept to up to 4 crossings after it.

Each kept word is tagged with the number of the event that owns its crossing, and with a relative crossing index inside that event's window. The tagged word then goes to the write port of a downstream FIFO. All other words are discarded. When windows overlap, each crossing is given to exactly one event. A crossing that carries an accept always belongs to that accept.

Internally the block holds each word back long enough for accepts up to 3 crossings in the future to be known before it decides. Ownership of each crossing is then kept for 8 crossings, so that words arriving late can still find their owner.

Top module: `twa_event_allocator`

## Requirements
- R1: After a synchronous reset, `fifo_wr_o` and `overflow_o` are 0, and the next accept is numbered event 0.
- R2: A word sampled with `word_vld_i` high in crossing T with lag d originates from crossing T−d. It is written to the FIFO only if that crossing is owned by some event. Otherwise it is dropped.
- R3: An accept in crossing A claims crossings A−pre through A+post. Here pre = `pre_len_i` (at most 3) and post = `post_len_i`, where any value above 4 acts as 4.
- R4: A crossing in which an accept occurs is always owned by that accept, with relative index 3.
- R5: When windows overlap, a crossing C without its own accept is handled in this order:
  - It goes to the nearest later accept within pre crossings after C.
  - Failing that, it goes to the most recent earlier accept within post crossings before C.
  - So a later event never takes the accept crossing of an earlier event, or anything before that crossing.
- R6: `fifo_data_o` = {event number, relative index, payload}:
  - The event number (width EVT_W) counts the accepts seen since reset, modulo 2^EVT_W.
  - The relative index is 3 bits, equal to C − A + 3.
  - The payload occupies the low PAYLOAD_W bits.
- R7: A word sampled at clock edge n that is kept appears on `fifo_wr_o`/`fifo_data_o` after edge n+6. Kept words leave in arrival order.
- R8: A kept word is dropped if `fifo_full_i` is high in the cycle before its write would appear. Such a drop sets `overflow_o`, which stays set until reset.
- R9: `fifo_wr_o` is never high unless a valid word was sampled exactly 6 edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_len_i | input | 2 | Crossings kept before each accept (0..3) |
| post_len_i | input | 3 | Crossings kept after each accept (values above 4 act as 4) |
| accept_i | input | 1 | Trigger accept for the current crossing |
| word_vld_i | input | 1 | Input word valid |
| word_data_i | input | PAYLOAD_W | Input payload |
| word_dly_i | input | 3 | Lag of the word behind its crossing of origin |
| fifo_full_i | input | 1 | Downstream FIFO full |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | EVT_W+3+PAYLOAD_W | {event number, relative index, payload} |
| overflow_o | output | 1 | Sticky flag: a kept word was lost to a full FIFO |

## Verification
The checker watches the back-pressure path on every cycle:
- no write follows a full cycle;
- the overflow flag rises only after a full cycle and never falls without reset;
- every write traces back to a valid input word exactly six edges before.

Window boundaries, the ownership rule for overlapping and back-to-back accepts, the event numbering and the relative indices depend on the history of accepts and cannot be stated as a local property. The bench's scenarios show these by comparing every write against a reference allocation computed from the requirements.

// File: rtl/twa_pkg.sv
package twa_pkg;
  localparam int PRE_MAX  = 3;
  localparam int POST_MAX = 4;
  localparam int SPAN     = PRE_MAX + POST_MAX + 1;
  localparam int REL_W    = $clog2(SPAN);
  localparam int DLY_W    = 3;
  localparam int DLY_N    = 1 << DLY_W;
  localparam int PRE_W    = $clog2(PRE_MAX + 1);
  localparam int POST_W   = $clog2(POST_MAX + 1);
  // word stages before the decision: lookahead for pre-window plus resolve/register hops
  localparam int PIPE_N   = PRE_MAX + 2;
  localparam int LATENCY  = PIPE_N + 1;

  typedef logic [REL_W-1:0] rel_t;
  typedef logic [DLY_W-1:0] dly_t;
endpackage

// File: rtl/twa_accept_hist.sv
module twa_accept_hist
  import twa_pkg::*;
#(
  parameter int EVT_W = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       accept_i,
  output logic [SPAN-1:0]            acc_o,
  output logic [SPAN-1:0][EVT_W-1:0] evt_o
);
  logic [EVT_W-1:0] evt_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o   <= '0;
      evt_o   <= '0;
      evt_cnt <= '0;
    end else begin
      acc_o[0] <= accept_i;
      evt_o[0] <= evt_cnt;
      for (int k = 1; k < SPAN; k++) begin
        acc_o[k] <= acc_o[k-1];
        evt_o[k] <= evt_o[k-1];
      end
      if (accept_i) evt_cnt <= evt_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/twa_owner_resolve.sv
module twa_owner_resolve
  import twa_pkg::*;
#(
  parameter int EVT_W = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [PRE_W-1:0]            pre_len_i,
  input  logic [POST_W-1:0]           post_len_i,
  input  logic [SPAN-1:0]             acc_i,
  input  logic [SPAN-1:0][EVT_W-1:0]  evt_i,
  output logic [DLY_N-1:0]            own_vld_o,
  output logic [DLY_N-1:0][EVT_W-1:0] own_evt_o,
  output rel_t [DLY_N-1:0]            own_rel_o
);
  logic             hit;
  logic [EVT_W-1:0] sel_evt;
  rel_t             sel_rel;

  // Resolves crossing (now - PRE_MAX); slot k of acc_i is that crossing's
  // accept offset giving relative index k directly.
  always_comb begin
    int pe;
    int po;
    pe = (int'(pre_len_i) > PRE_MAX) ? PRE_MAX : int'(pre_len_i);
    po = (int'(post_len_i) > POST_MAX) ? POST_MAX : int'(post_len_i);
    hit     = 1'b0;
    sel_evt = '0;
    sel_rel = '0;
    // lowest priority: most recent earlier accept inside its post-window
    for (int k = SPAN - 1; k > PRE_MAX; k--) begin
      if (acc_i[k] && (k <= PRE_MAX + po)) begin
        hit = 1'b1; sel_evt = evt_i[k]; sel_rel = rel_t'(k);
      end
    end
    // higher: nearest later accept inside its pre-window
    for (int k = 0; k < PRE_MAX; k++) begin
      if (acc_i[k] && (k >= PRE_MAX - pe)) begin
        hit = 1'b1; sel_evt = evt_i[k]; sel_rel = rel_t'(k);
      end
    end
    // highest: the crossing's own accept
    if (acc_i[PRE_MAX]) begin
      hit = 1'b1; sel_evt = evt_i[PRE_MAX]; sel_rel = rel_t'(PRE_MAX);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_vld_o <= '0;
      own_evt_o <= '0;
      own_rel_o <= '0;
    end else begin
      own_vld_o[0] <= hit;
      own_evt_o[0] <= sel_evt;
      own_rel_o[0] <= sel_rel;
      for (int m = 1; m < DLY_N; m++) begin
        own_vld_o[m] <= own_vld_o[m-1];
        own_evt_o[m] <= own_evt_o[m-1];
        own_rel_o[m] <= own_rel_o[m-1];
      end
    end
  end
endmodule

// File: rtl/twa_word_delay.sv
module twa_word_delay
  import twa_pkg::*;
#(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld_i,
  input  logic [W-1:0] data_i,
  output logic         vld_o,
  output logic [W-1:0] data_o
);
  logic [PIPE_N-1:0]        vld_q;
  logic [PIPE_N-1:0][W-1:0] data_q;

  genvar g;
  generate
    for (g = 0; g < PIPE_N; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) vld_q[g] <= 1'b0;
          else     vld_q[g] <= vld_i;
          data_q[g] <= data_i;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst) vld_q[g] <= 1'b0;
          else     vld_q[g] <= vld_q[g-1];
          data_q[g] <= data_q[g-1];
        end
      end
    end
  endgenerate

  assign vld_o  = vld_q[PIPE_N-1];
  assign data_o = data_q[PIPE_N-1];
endmodule

// File: rtl/twa_event_allocator.sv
module twa_event_allocator
  import twa_pkg::*;
#(
  parameter int PAYLOAD_W = 16,
  parameter int EVT_W     = 10
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [PRE_W-1:0]                 pre_len_i,
  input  logic [POST_W-1:0]                post_len_i,
  input  logic                             accept_i,
  input  logic                             word_vld_i,
  input  logic [PAYLOAD_W-1:0]             word_data_i,
  input  logic [DLY_W-1:0]                 word_dly_i,
  input  logic                             fifo_full_i,
  output logic                             fifo_wr_o,
  output logic [EVT_W+REL_W+PAYLOAD_W-1:0] fifo_data_o,
  output logic                             overflow_o
);
  localparam int WORD_W = DLY_W + PAYLOAD_W;

  logic [SPAN-1:0]            acc_sr;
  logic [SPAN-1:0][EVT_W-1:0] evt_sr;
  logic [DLY_N-1:0]            own_vld;
  logic [DLY_N-1:0][EVT_W-1:0] own_evt;
  rel_t [DLY_N-1:0]            own_rel;
  logic                        pipe_vld;
  logic [WORD_W-1:0]           pipe_data;
  dly_t                        pipe_dly;
  logic                        keep;

  twa_accept_hist #(.EVT_W(EVT_W)) u_hist (
    .clk(clk), .rst(rst), .accept_i(accept_i), .acc_o(acc_sr), .evt_o(evt_sr)
  );

  twa_owner_resolve #(.EVT_W(EVT_W)) u_res (
    .clk(clk), .rst(rst), .pre_len_i(pre_len_i), .post_len_i(post_len_i),
    .acc_i(acc_sr), .evt_i(evt_sr),
    .own_vld_o(own_vld), .own_evt_o(own_evt), .own_rel_o(own_rel)
  );

  twa_word_delay #(.W(WORD_W)) u_dly (
    .clk(clk), .rst(rst), .vld_i(word_vld_i), .data_i({word_dly_i, word_data_i}),
    .vld_o(pipe_vld), .data_o(pipe_data)
  );

  // the word's lag indexes straight into the ownership history
  assign pipe_dly = pipe_data[WORD_W-1 -: DLY_W];
  assign keep     = pipe_vld && own_vld[pipe_dly];

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_wr_o   <= 1'b0;
      fifo_data_o <= '0;
      overflow_o  <= 1'b0;
    end else begin
      fifo_wr_o <= keep && !fifo_full_i;
      if (keep && !fifo_full_i)
        fifo_data_o <= {own_evt[pipe_dly], own_rel[pipe_dly], pipe_data[PAYLOAD_W-1:0]};
      if (keep && fifo_full_i)
        overflow_o <= 1'b1;
    end
  end
endmodule

// File: rtl/twa_checker.sv
module twa_checker
  import twa_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic word_vld_i,
  input logic fifo_full_i,
  input logic fifo_wr_o,
  input logic overflow_o
);
  a_r8_no_write_after_full: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_o |-> !$past(fifo_full_i));

  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow_o |=> overflow_o);

  a_r8_overflow_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow_o) |-> $past(fifo_full_i));

  a_r9_write_needs_word: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_o |-> $past(word_vld_i, LATENCY));
endmodule

bind twa_event_allocator twa_checker u_chk (
  .clk(clk), .rst(rst), .word_vld_i(word_vld_i), .fifo_full_i(fifo_full_i),
  .fifo_wr_o(fifo_wr_o), .overflow_o(overflow_o)
);

// File: tb/sim_twa_event_allocator.sv
`timescale 1ns/1ps
module sim_twa_event_allocator;
  import twa_pkg::*;
  localparam int PW = 16;
  localparam int EW = 10;
  localparam int DW = EW + REL_W + PW;
  localparam int NDRV = 16;

  // {pre[1:0], post[2:0], accept mask over crossings 0..15}
  localparam int NVEC = 7;
  localparam logic [20:0] VEC [NVEC] = '{
    {2'd0, 3'd0, 16'h0010},   // single crossing window
    {2'd3, 3'd4, 16'h0020},   // full 8-crossing span
    {2'd2, 3'd3, 16'h0048},   // overlap, later takes post crossings
    {2'd3, 3'd4, 16'h0050},   // earlier accept crossing kept by its own
    {2'd1, 3'd7, 16'h1004},   // post clamp
    {2'd3, 3'd4, 16'h0030},   // back-to-back accepts
    {2'd0, 3'd0, 16'h0000}    // no accept: all dropped
  };

  logic clk = 0;
  logic rst = 1;
  logic [PRE_W-1:0]  pre_len = '0;
  logic [POST_W-1:0] post_len = '0;
  logic accept = 0, wvld = 0, full = 0;
  logic [PW-1:0] wdata = '0;
  logic [DLY_W-1:0] wdly = '0;
  logic fifo_wr, overflow;
  logic [DW-1:0] fifo_data;

  always #5 clk = ~clk;

  twa_event_allocator #(.PAYLOAD_W(PW), .EVT_W(EW)) u0 (
    .clk(clk), .rst(rst), .pre_len_i(pre_len), .post_len_i(post_len),
    .accept_i(accept), .word_vld_i(wvld), .word_data_i(wdata), .word_dly_i(wdly),
    .fifo_full_i(full), .fifo_wr_o(fifo_wr), .fifo_data_o(fifo_data), .overflow_o(overflow)
  );

  int n_chk = 0, n_fail = 0;
  int ecount = 0;
  int cap_n = 0;
  logic [DW-1:0] cap_d [64];
  int cap_t [64];
  bit done = 0;

  always @(posedge clk) ecount <= ecount + 1;
  always @(negedge clk) if (fifo_wr === 1'b1 && cap_n < 64) begin
    cap_d[cap_n] = fifo_data;
    cap_t[cap_n] = ecount;
    cap_n = cap_n + 1;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; accept = 0; wvld = 0; full = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    cap_n = 0;
  endtask

  // reference ownership of crossing o; returns 1 and the tag when owned
  function automatic bit ref_owner(input bit acc[32], input int o, input int pre, input int post,
                                   output int evt, output int rel);
    int a;
    int pe;
    int po;
    pe = (pre > 3) ? 3 : pre;
    po = (post > 4) ? 4 : post;
    a = -1;
    if (acc[o]) a = o;
    if (a < 0) for (int c = o + 1; c <= o + pe; c++) if (a < 0 && acc[c]) a = c;
    if (a < 0) for (int c = o - 1; c >= o - po && c >= 0; c--) if (a < 0 && acc[c]) a = c;
    if (a < 0) return 0;
    evt = 0;
    for (int c = 0; c < a; c++) if (acc[c]) evt++;
    rel = o - a + 3;
    return 1;
  endfunction

  task automatic run_vec(input int idx);
    bit acc[32];
    int pre;
    int post;
    int drv_t [NDRV];
    bit drv_v [NDRV];
    int drv_d [NDRV];
    logic [PW-1:0] drv_p [NDRV];
    int ne;
    pre  = int'(VEC[idx][20:19]);
    post = int'(VEC[idx][18:16]);
    for (int c = 0; c < 32; c++) acc[c] = (c < NDRV) ? VEC[idx][c] : 1'b0;
    pre_len = VEC[idx][20:19];
    post_len = VEC[idx][18:16];
    do_reset();
    for (int i = 0; i < NDRV; i++) begin
      int d;
      @(posedge clk); #1;
      d = (i * 3 + idx) % 8;
      if (d > i) d = i;
      drv_t[i] = ecount;
      drv_v[i] = (i % 5) != 4;
      drv_d[i] = d;
      drv_p[i] = {4'(idx), 4'(d), 8'(i)};
      accept = acc[i];
      wvld = drv_v[i];
      wdly = DLY_W'(d);
      wdata = drv_p[i];
    end
    @(posedge clk); #1;
    accept = 0; wvld = 0;
    repeat (14) @(posedge clk);
    #1;
    ne = 0;
    for (int i = 0; i < NDRV; i++) begin
      int ev;
      int rl;
      if (drv_v[i] && ref_owner(acc, i - drv_d[i], pre, post, ev, rl)) begin
        logic [DW-1:0] exp_d;
        exp_d = {EW'(ev), REL_W'(rl), drv_p[i]};
        if (ne < cap_n) begin
          // R2 R3 R4 R5 R6: owner, event number and relative index of each kept word
          check(cap_d[ne] == exp_d, "R6 tag (R2-window R3 R4 R5 allocation)", cap_d[ne], exp_d);
          // R7: fixed latency and arrival order
          check(cap_t[ne] == drv_t[i] + LATENCY, "R7 latency", cap_t[ne], drv_t[i] + LATENCY);
        end
        ne++;
      end
    end
    // R2: words outside every window produce no write
    check(cap_n == ne, "R2 kept word count", cap_n, ne);
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    check(fifo_wr == 1'b0, "R1 write idle after reset", fifo_wr, 0);
    check(overflow == 1'b0, "R1 overflow clear after reset", overflow, 0);

    for (int v = 0; v < NVEC; v++) run_vec(v);

    // R8: full FIFO drops the kept word and sets the sticky flag
    pre_len = '0; post_len = '0;
    do_reset();
    full = 1;
    @(posedge clk); #1;
    accept = 1; wvld = 1; wdly = '0; wdata = 16'hBEEF;
    @(posedge clk); #1;
    accept = 0; wvld = 0;
    repeat (10) @(posedge clk);
    #1;
    check(cap_n == 0, "R8 no write while full", cap_n, 0);
    check(overflow == 1'b1, "R8 overflow set", overflow, 1);
    full = 0;
    repeat (5) @(posedge clk);
    #1;
    check(overflow == 1'b1, "R8 overflow sticky", overflow, 1);

    // R1: reset clears overflow, numbering restarts at event 0
    do_reset();
    #1;
    check(overflow == 1'b0, "R1 overflow cleared by reset", overflow, 0);
    @(posedge clk); #1;
    accept = 1; wvld = 1; wdly = '0; wdata = 16'h1234;
    @(posedge clk); #1;
    accept = 0; wvld = 0;
    repeat (10) @(posedge clk);
    #1;
    check(cap_n == 1, "R1 one write after reset", cap_n, 1);
    check(cap_d[0] == {EW'(0), REL_W'(3), 16'h1234}, "R1 first event is 0", cap_d[0],
          {EW'(0), REL_W'(3), 16'h1234});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule